// File: doc/BRIEF.md
# Fractional-Multiplier CPU Clock Enable Generator

This block turns a free-running parent clock into a CPU-domain clock enable whose average rate is the parent rate scaled by mult/32 and then divided by a fixed post-divider (2 by default). Inside each run of 32 parent cycles, a modulo-32 accumulator adds mult on every cycle and passes the cycle whenever the sum wraps. This spreads the mult passed cycles as evenly as the ratio allows. A post-divider then keeps every POST_DIV-th passed cycle.

Software sees two 32-bit registers behind a simple write/read port. The ratio register (select 0) holds a 5-bit code at bit offset FIELD_LSB, and the code stores 32 minus mult. The control register (select 1) holds a commit request in bit 31. Writing a code only stages it. Setting the commit bit arms a small state machine, and the new code becomes active only where the 32-cycle pattern wraps. The commit bit clears itself one cycle after the switch.

The state machine has three states:
- `ST_IDLE`: no change pending.
- `ST_ARMED`: a commit was requested and the block waits for the pattern wrap.
- `ST_COMMIT`: the new code has just been loaded and the commit bit still reads 1.

The transitions are:
- `IDLE->ARMED` on a control write with bit 31 set.
- `ARMED->COMMIT` on the cycle where the phase is 31.
- `COMMIT->IDLE` unconditionally.

Top module: `cpu_ratio_clkgen`

## Requirements
- R1: After reset, both registers read 0. The active code is 0, so mult is 32 and the output emits 32 enables in every 64 parent cycles.
- R2: The ratio register holds the code in bits FIELD_LSB+4..FIELD_LSB (bits 12..8 by default), with code = 32 − mult. All other bits read 0 and ignore writes.
- R3: Writing the ratio register alone does not change the output rate.
- R4: A control-register write with bit 31 = 1 while idle makes bit 31 of the control register read 1 from the next cycle.
- R5: The commit bit clears by itself 2 to 33 cycles after the write that set it. A second commit write while it is set neither restarts nor extends the wait.
- R6: A new code takes effect only at the wrap of the 32-cycle phase, from phase 31 to phase 0. The commit bit is read as 0 for the first time at phase 1.
- R7: Writes to the ratio register while the commit bit reads 1 are ignored.
- R8: A control write with bit 31 = 0 has no effect.
- R9: With code c committed, mult = 32 − c. Any window of 32·POST_DIV consecutive cycles then contains exactly mult enables, and every enable coincides with a passed accumulator cycle.
- R10: The extremes are covered: code 31 gives 1 enable per 64 cycles, and code 0 gives 32 enables per 64 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 ratio register, 1 control register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 ratio register, 1 control register |
| rd_data | output | 32 | Combinational read data |
| clk_en | output | 1 | CPU clock enable, one parent cycle wide per pulse |

## Verification
The assertions assume that `wr_en`, `wr_sel` and `wr_data` are free of X whenever reset is released, and that the parent clock runs without gaps so that the phase counter advances once per cycle. The stimulus drives every input at the falling edge from tasks. It holds `wr_en` low outside single-cycle writes and releases reset at a falling edge, so the bench's own cycle count stays in step with the block's phase.

// File: rtl/cpu_ratio_pkg.sv
package cpu_ratio_pkg;
    localparam int CODE_W = 5;
    localparam int PHASES = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_COMMIT = 2'd2
    } kick_state_e;
endpackage

// File: rtl/cpu_ratio_regs.sv
module cpu_ratio_regs
    import cpu_ratio_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_field,
    input  logic              wr_kick,
    input  logic              rd_sel,
    input  logic              wrap,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] active_code,
    output logic              kick
);
    localparam int KICK_BIT = DATA_W - 1;

    kick_state_e state, state_nxt;
    logic [CODE_W-1:0] staged;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (wr_en && wr_sel && wr_kick) state_nxt = ST_ARMED;
            ST_ARMED:  if (wrap) state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // staged and active ratio codes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged      <= '0;
            active_code <= '0;
        end else begin
            if (wr_en && !wr_sel && state == ST_IDLE)
                staged <= wr_field;
            if (state == ST_ARMED && wrap)
                active_code <= staged;
        end
    end

    // outputs
    always_comb begin
        kick    = (state != ST_IDLE);
        rd_data = '0;
        if (rd_sel) rd_data[KICK_BIT] = kick;
        else        rd_data[FIELD_LSB +: CODE_W] = staged;
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && wr_en && !wr_sel) |=> $stable(staged)); // R7
    AST_KICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kick) |-> $past(wr_en && wr_sel && wr_kick)); // R4
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> !kick); // R5
endmodule

// File: rtl/cpu_ratio_accum.sv
module cpu_ratio_accum
    import cpu_ratio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] phase,
    output logic              wrap,
    output logic              pass
);
    logic [CODE_W-1:0] acc;
    logic [CODE_W:0]   mult;
    logic [CODE_W:0]   sum;

    always_comb begin
        mult = 6'(PHASES) - {1'b0, code};
        sum  = {1'b0, acc} + mult;
        pass = sum[CODE_W];
        wrap = (phase == CODE_W'(PHASES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            phase <= '0;
        end else begin
            acc   <= sum[CODE_W-1:0];
            phase <= phase + 1'b1;
        end
    end

    AST_ACC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> (acc == '0)); // R9
endmodule

// File: rtl/cpu_ratio_postdiv.sv
module cpu_ratio_postdiv #(
    parameter int POST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pass,
    output logic en
);
    localparam int CNT_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POST_DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign en = pass && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (pass) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/cpu_ratio_clkgen.sv
module cpu_ratio_clkgen
    import cpu_ratio_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int POST_DIV  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        clk_en
);
    logic [CODE_W-1:0] active_code;
    logic [CODE_W-1:0] phase;
    logic              wrap;
    logic              pass;
    logic              kick;

    cpu_ratio_regs #(.DATA_W(32), .FIELD_LSB(FIELD_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_field(wr_data[FIELD_LSB +: CODE_W]), .wr_kick(wr_data[31]),
        .rd_sel(rd_sel), .wrap(wrap), .rd_data(rd_data),
        .active_code(active_code), .kick(kick)
    );

    cpu_ratio_accum u_accum (
        .clk(clk), .rst_n(rst_n), .code(active_code),
        .phase(phase), .wrap(wrap), .pass(pass)
    );

    cpu_ratio_postdiv #(.POST_DIV(POST_DIV)) u_postdiv (
        .clk(clk), .rst_n(rst_n), .pass(pass), .en(clk_en)
    );

    AST_ACTIVE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_code) |-> (phase == '0)); // R6
    AST_EN_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> pass); // R9
    AST_SWITCH_WHILE_KICKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_code) |-> kick); // R6
endmodule

// File: tb/cpu_ratio_clkgen_tb.sv
`timescale 1ns/1ps
module cpu_ratio_clkgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        clk_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    cpu_ratio_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .clk_en(clk_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_en) c++;
        end
    endtask

    task automatic wait_clear(output int waited, output int ph);
        logic [31:0] d;
        waited = 0;
        rd(1'b1, d);
        while (d[31] && waited < 40) begin
            @(negedge clk);
            waited++;
            rd(1'b1, d);
        end
        ph = cyc % 32;
    endtask

    task automatic commit(input int code, input string req);
        int w, ph, c;
        wr(1'b0, 32'(code) << 8);
        wr(1'b1, 32'h8000_0000);
        wait_clear(w, ph);
        check(w >= 1 && w <= 33, "R5 latency", w, 33);
        check(ph == 1, "R6 clear phase", ph, 1);
        count_en(64, c);
        check(c == 32 - code, req, c, 32 - code);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int c;
        rd(1'b0, d); check(d == 0, "R1 ratio reset", d, 0);
        rd(1'b1, d); check(d == 0, "R1 control reset", d, 0);
        count_en(64, c); check(c == 32, "R1 R10 full rate", c, 32);
    endtask

    task automatic t_field();
        logic [31:0] d;
        int c;
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check(d == 32'h0000_1F00, "R2 field only", d, 32'h1F00);
        count_en(64, c); check(c == 32, "R3 staged no effect", c, 32);
    endtask

    task automatic t_kick();
        logic [31:0] d;
        int w, ph, c;
        wr(1'b1, 32'h8000_0000);
        rd(1'b1, d); check(d == 32'h8000_0000, "R4 kick set", d, 32'h8000_0000);
        wait_clear(w, ph);
        check(w >= 1 && w <= 33, "R5 self clear", w, 33);
        check(ph == 1, "R6 wrap boundary", ph, 1);
        count_en(64, c); check(c == 1, "R10 code 31", c, 1);
    endtask

    task automatic t_ignore_busy();
        logic [31:0] d;
        int w, ph, c;
        wr(1'b0, 32'h0000_1000);
        wr(1'b1, 32'h8000_0000);
        wr(1'b0, 32'h0000_0300);
        rd(1'b0, d); check(d == 32'h0000_1000, "R7 busy write ignored", d, 32'h1000);
        wr(1'b1, 32'h8000_0000);   // second kick while pending
        wait_clear(w, ph);
        check(w <= 32, "R5 no restart", w, 32);
        count_en(64, c); check(c == 16, "R7 R9 mult 16", c, 16);
    endtask

    task automatic t_noop_ctrl();
        logic [31:0] d;
        int c;
        wr(1'b1, 32'h7FFF_FFFF);
        rd(1'b1, d); check(d == 0, "R8 ctrl no kick", d, 0);
        count_en(64, c); check(c == 16, "R8 rate kept", c, 16);
    endtask

    task automatic t_rates();
        int c;
        commit(5,  "R9 mult 27");
        commit(21, "R9 mult 11");
        count_en(128, c); check(c == 22, "R9 two windows", c, 22);
        commit(0,  "R10 code 0");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_field();
                t_kick();
                t_ignore_busy();
                t_noop_ctrl();
                t_rates();
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule